// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a hardware watchdog that software must service with a rolling 7-bit key. Each command write carries a start value for the countdown, a command bit (start or stop) and a key. A write is honoured only when its key is the bitwise inverse of the key in the last honoured write. A start loads the countdown and arms it, and a start issued while running is the service ("kick") operation. A stop halts the countdown.

While armed, an 8-bit counter steps down once per prescaler period. The default prescaler is 17 bits, which gives roughly 763 Hz from a 100 MHz clock. The block gives two warnings. When the count falls from 2 to 1, a one-clock non-maskable interrupt pulse goes out. When the count reaches 0, a reset request goes out and stays high until the block's own synchronous reset. A write with a bad key is dropped and sets a sticky error flag, which software clears with a one-cycle clear strobe.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, `armed`, `count`, `nmi`, `bite` and `key_err` are all 0.
- R2: The first write after reset is honoured whatever its key, and that key becomes the reference for the next write.
- R3: Every later write is honoured only if its key equals the reference XOR 0x7F. An honoured write replaces the reference with its own key.
- R4: A write with a bad key changes neither `armed`, `count` nor the reference key.
- R5: A write with a bad key sets `key_err` in the next cycle. `key_err` stays high until `err_clr` is high at a clock edge with no bad write. If a bad write and `err_clr` arrive together, the flag is set.
- R6: An honoured write with `wr_start`=1 loads `count` from `wr_cnt`, sets `armed` and clears the prescaler. The first decrement lands 2^PRESCALE_W cycles after the accepting edge.
- R7: While armed, `count` decrements exactly once every 2^PRESCALE_W cycles.
- R8: `nmi` is high for exactly one cycle, at the step that takes `count` from 2 to 1. A start value of 0 or 1 yields no pulse.
- R9: `bite` rises at the step that takes `count` from 1 to 0, or at the first step after a start with value 0. It then stays high until `rst`.
- R10: An honoured write with `wr_start`=0 clears `armed`. After that, `count` holds and neither `nmi` nor `bite` fires.
- R11: An honoured start while armed reloads `count` and restarts the full period, which postpones `bite` accordingly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Command write strobe |
| wr_start | input | 1 | Command: 1 start/kick, 0 stop |
| wr_cnt | input | CNT_W | Countdown start value |
| wr_key | input | KEY_W | Key presented with the write |
| err_clr | input | 1 | Clears the bad-key flag |
| armed | output | 1 | Countdown running |
| count | output | CNT_W | Current countdown value |
| nmi | output | 1 | One-cycle warning pulse |
| bite | output | 1 | Held reset request |
| key_err | output | 1 | Sticky bad-key flag |

## Verification
A wrong reference key shows at the ports on the very next write. A valid kick is then refused, so `key_err` rises and `armed` fails to change one cycle later. A prescaler that is off by any amount moves every `count` step, and with it the `nmi` and `bite` edges, by a whole number of cycles. The sweep detects this at the first step after a start. A wrong decrement or terminal compare shows up as a pulse in the wrong cycle, a missing pulse, or a `bite` that comes early or late against the arithmetic schedule of 2^PRESCALE_W cycles per step.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic {
    WD_STOP  = 1'b0,
    WD_START = 1'b1
  } wd_cmd_e;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int PRESCALE_W = 17
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  logic [PRESCALE_W-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst || clr) div_q <= '0;
    else            div_q <= div_q + 1'b1;
  end

  assign tick = &div_q;

  // R6: clearing the divider suppresses a step in the following cycle
  assert_clr_no_tick_R6: assert property (@(posedge clk) disable iff (rst)
    clr |=> !tick);
endmodule

// File: rtl/wdt_keycheck.sv
module wdt_keycheck #(
  parameter int KEY_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [KEY_W-1:0] wr_key,
  input  logic             err_clr,
  output logic             accept,
  output logic             key_err
);
  logic [KEY_W-1:0] ref_key;
  logic             have_ref;
  logic             bad_wr;

  assign accept = wr_en && (!have_ref || (wr_key == ~ref_key));
  assign bad_wr = wr_en && !accept;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_key  <= '0;
      have_ref <= 1'b0;
      key_err  <= 1'b0;
    end else begin
      if (accept) begin
        ref_key  <= wr_key;
        have_ref <= 1'b1;
      end
      if (bad_wr)       key_err <= 1'b1;
      else if (err_clr) key_err <= 1'b0;
    end
  end

  // R2: once a reference exists it is never lost before reset
  assert_ref_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    have_ref |=> have_ref);
  // R4: a refused write leaves the reference untouched
  assert_bad_keeps_ref_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !accept) |=> $stable(ref_key));
  // R5: the flag only rises after a write strobe
  assert_err_rise_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(key_err) |-> $past(wr_en));
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             halt,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             running,
  output logic [CNT_W-1:0] count,
  output logic             nmi,
  output logic             bite
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      count   <= '0;
      nmi     <= 1'b0;
      bite    <= 1'b0;
    end else begin
      nmi <= 1'b0;
      if (load) begin
        count   <= load_val;
        running <= 1'b1;
      end else if (halt) begin
        running <= 1'b0;
      end else if (running && tick) begin
        if (count > ONE) begin
          count <= count - 1'b1;
          if (count == TWO) nmi <= 1'b1;
        end else begin
          count <= '0;
          bite  <= 1'b1;
        end
      end
    end
  end

  // R8: the warning is a single-cycle pulse
  assert_nmi_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    nmi |=> !nmi);
  // R8: the warning only follows a step of a running countdown
  assert_nmi_from_step_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(nmi) |-> ($past(running) && $past(tick)));
  // R9: the reset request holds until reset
  assert_bite_hold_R9: assert property (@(posedge clk) disable iff (rst)
    bite |=> bite);
  // R7: without a load the count never grows
  assert_no_growth_R7: assert property (@(posedge clk) disable iff (rst)
    !load |=> (count <= $past(count)));
  // R10: a stopped countdown holds its value
  assert_hold_stopped_R10: assert property (@(posedge clk) disable iff (rst)
    (!running && !load) |=> $stable(count));
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdt_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int KEY_W      = 7,
  parameter int PRESCALE_W = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_start,
  input  logic [CNT_W-1:0] wr_cnt,
  input  logic [KEY_W-1:0] wr_key,
  input  logic             err_clr,
  output logic             armed,
  output logic [CNT_W-1:0] count,
  output logic             nmi,
  output logic             bite,
  output logic             key_err
);
  logic    accept;
  logic    tick;
  logic    do_start;
  logic    do_stop;
  wd_cmd_e cmd;

  assign cmd      = wd_cmd_e'(wr_start);
  assign do_start = accept && (cmd == WD_START);
  assign do_stop  = accept && (cmd == WD_STOP);

  wdt_keycheck #(.KEY_W(KEY_W)) u_key (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_key(wr_key),
    .err_clr(err_clr), .accept(accept), .key_err(key_err)
  );

  wdt_prescaler #(.PRESCALE_W(PRESCALE_W)) u_pre (
    .clk(clk), .rst(rst), .clr(do_start), .tick(tick)
  );

  wdt_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load(do_start), .halt(do_stop),
    .load_val(wr_cnt), .tick(tick), .running(armed), .count(count),
    .nmi(nmi), .bite(bite)
  );

  // R6: an accepted start arms the block with the written value
  assert_start_loads_R6: assert property (@(posedge clk) disable iff (rst)
    do_start |=> (armed && count == $past(wr_cnt)));
  // R10: an accepted stop disarms
  assert_stop_disarms_R10: assert property (@(posedge clk) disable iff (rst)
    do_stop |=> !armed);
  // R4: a refused write leaves the arm state alone
  assert_bad_no_effect_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !accept) |=> (armed == $past(armed)));
endmodule

// File: tb/keyed_watchdog_bench.sv
module keyed_watchdog_bench;
  localparam int CW = 8;
  localparam int KW = 7;
  localparam int PW = 3;
  localparam int PER = 1 << PW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, wr_start = 1'b0, err_clr = 1'b0;
  logic [CW-1:0] wr_cnt = '0;
  logic [KW-1:0] wr_key = '0;
  logic armed, nmi, bite, key_err;
  logic [CW-1:0] count;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  keyed_watchdog #(.CNT_W(CW), .KEY_W(KW), .PRESCALE_W(PW)) u_keyed_watchdog (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_start(wr_start),
    .wr_cnt(wr_cnt), .wr_key(wr_key), .err_clr(err_clr),
    .armed(armed), .count(count), .nmi(nmi), .bite(bite), .key_err(key_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic do_write(input logic st, input logic [CW-1:0] c, input logic [KW-1:0] k);
    wr_en = 1'b1; wr_start = st; wr_cnt = c; wr_key = k;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Watches a run from a start of value n; cyc counts edges after the accepting one
  task automatic watch_run(input int n);
    int last;
    last = PER * ((n < 1) ? 1 : n) + 3;
    for (int cyc = 0; cyc <= last; cyc++) begin
      int ec;
      bit en, eb;
      ec = n - cyc / PER;
      if (ec < 0) ec = 0;
      en = (n >= 2) && (cyc == PER * (n - 1));
      eb = (cyc >= PER * ((n < 1) ? 1 : n));
      chk(count == CW'(ec), "R7 count", count, ec);
      chk(nmi == en, "R8 nmi", nmi, en);
      chk(bite == eb, "R9 bite", bite, eb);
      @(negedge clk);
    end
  endtask

  initial begin
    int stopped_cnt;
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk(!armed, "R1 armed", armed, 0);
    chk(count == 0, "R1 count", count, 0);
    chk(!nmi && !bite, "R1 nmi/bite", {nmi, bite}, 0);
    chk(!key_err, "R1 key_err", key_err, 0);

    // Countdown sweep, R6 timing of first step
    for (int n = 0; n <= 20; n++) begin
      do_reset();
      do_write(1'b1, CW'(n), 7'h2A);
      chk(armed, "R6 armed", armed, 1);
      watch_run(n);
    end

    // Key sweep: R2 any first key, R4 bad key ignored, R3 inverse accepted
    for (int k = 0; k < 128; k++) begin
      do_reset();
      do_write(1'b1, 8'd200, KW'(k));
      chk(armed, "R2 first key", armed, 1);
      do_write(1'b0, 8'd0, KW'(k));
      chk(armed && count == 200, "R4 bad stop ignored", armed, 1);
      chk(key_err, "R5 err set", key_err, 1);
      do_write(1'b0, 8'd0, KW'(k) ^ 7'h7F);
      chk(!armed, "R3 inverse key stop", armed, 0);
      chk(key_err, "R5 err sticky", key_err, 1);
    end

    // R5 clear, and set wins over clear
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
    chk(!key_err, "R5 err cleared", key_err, 0);
    err_clr = 1'b1;
    do_write(1'b1, 8'd9, 7'h00);
    err_clr = 1'b0;
    chk(key_err, "R5 set beats clear", key_err, 1);
    chk(!armed, "R4 bad start ignored", armed, 0);

    // R10 stop freezes count; R11 kick reloads
    do_reset();
    do_write(1'b1, 8'd5, 7'h11);
    repeat (PER + 2) @(negedge clk);
    do_write(1'b0, 8'd0, 7'h6E);
    stopped_cnt = count;
    chk(stopped_cnt == 4, "R10 count at stop", stopped_cnt, 4);
    repeat (10 * PER) @(negedge clk);
    chk(count == CW'(stopped_cnt) && !bite && !nmi, "R10 frozen", count, stopped_cnt);
    do_write(1'b1, 8'd3, 7'h11);
    repeat (PER + 3) @(negedge clk);
    chk(count == 2, "R11 running after restart", count, 2);
    do_write(1'b1, 8'd3, 7'h6E);
    chk(count == 3, "R11 kick reload", count, 3);
    repeat (3 * PER - 1) @(negedge clk);
    chk(!bite, "R11 no early bite", bite, 0);
    @(negedge clk);
    chk(bite, "R11 bite after kick", bite, 1);
    do_write(1'b0, 8'd0, 7'h11);
    repeat (4) @(negedge clk);
    chk(bite, "R9 bite held", bite, 1);
    do_reset();
    chk(!bite, "R9 bite cleared by rst", bite, 0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog timeout", 0, 1);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule